// File: doc/BRIEF.md
# In-line CRC-32 for a DMA channel

This block sits beside one DMA channel's data path and folds every 32-bit word that the channel moves into an Ethernet-style CRC-32, in the same clock edge that the word is transferred. The transfer takes no extra cycles. Firmware seeds the CRC by writing the CRC register, normally with all ones. The register holds the raw remainder, so firmware inverts it if it wants the final CRC value.

Once the channel reports that the payload is complete, the block can optionally issue one extra 32-bit write that carries the CRC to the destination word that follows the last payload word. It uses a request/acknowledge handshake for this write. While CRC is in use, the block holds off the channel's interrupt until the CRC and any appended write are finished. A build-time parameter removes the CRC hardware from channels that do not need it. On such a channel the enable reads back as zero and the outputs stay idle.

Top module: `dma_crc32_inline`

## Requirements
- R1: On each edge where `beat_valid` is high, CRC is enabled and the transfer size is 4 bytes, `crc_value` takes the CRC-32 (polynomial 0x04C11DB7, reflected form 0xEDB88320) of its old value and `beat_data`. Data bits are taken LSB first. For example, a seed of FFFFFFFFh followed by the word 00000000h gives DEBB20E3h.
- R2: After reset, `crc_value` is FFFFFFFFh and `app_req`, `irq_hold` and `size_err` are low. A `seed_we` edge loads `seed_data` into `crc_value`. If a beat arrives on the same edge, the seed write wins and the beat is not absorbed.
- R3: A beat that arrives with CRC enabled and `cfg_xfer_bytes` not equal to 4 leaves `crc_value` unchanged and sets `size_err`. `size_err` stays set until the next `seed_we`. While it is set, `xfer_done` produces no appended write.
- R4: When `xfer_done` is seen with CRC and append enabled and no size error, `app_req` rises on the next edge. At that point `app_data` equals the CRC that includes every absorbed beat, even one absorbed on the same edge as `xfer_done`. `app_addr` equals the last absorbed beat's `beat_addr` plus 4.
- R5: `app_req` stays high, with `app_addr` and `app_data` unchanged, until an edge with `app_ack` high. `app_req` is low after that edge.
- R6: `irq_hold` goes high on the edge that absorbs the first beat of a transfer. It stays high until the edge that sees `xfer_done` (no append) or `app_ack` (append), and is low after that edge. It is always high while `app_req` is high.
- R7: With `cfg_crc_en` low, beats leave `crc_value` unchanged, and `irq_hold` and `app_req` stay low.
- R8: `crc_en_rd` mirrors `cfg_crc_en` when `HAS_CRC` is 1. When `HAS_CRC` is 0 it reads 0, and `irq_hold` and `app_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_crc_en | input | 1 | CRC enable for the channel |
| cfg_append_en | input | 1 | Write the CRC to the destination after the payload |
| cfg_xfer_bytes | input | 3 | Channel transfer size in bytes |
| seed_we | input | 1 | Firmware write strobe for the CRC register |
| seed_data | input | 32 | Value written to the CRC register |
| beat_valid | input | 1 | A data word moves on this edge |
| beat_data | input | 32 | The word being moved |
| beat_addr | input | ADDR_W | Destination address of the word |
| xfer_done | input | 1 | The channel's payload is complete |
| app_ack | input | 1 | The appended CRC write has been accepted |
| crc_value | output | 32 | CRC register (raw remainder) |
| crc_en_rd | output | 1 | Readback of the CRC enable |
| size_err | output | 1 | CRC was used with a size other than 4 bytes |
| app_req | output | 1 | Request for the appended CRC write |
| app_addr | output | ADDR_W | Destination address of the appended write |
| app_data | output | 32 | Data of the appended write |
| irq_hold | output | 1 | Suppresses the channel interrupt |

## Verification
The last payload beat and `xfer_done` can arrive on the same edge. In that case the appended word must already contain that final beat, and its address must come from that beat. The bench places `xfer_done` at random, either on the last beat or on a separate later cycle. It then compares `app_data` and `app_addr` with a CRC and address it computes itself. A second collision, a seed write landing on the same edge as a beat, is driven directly, and the bench checks that only the seed is taken.

// File: rtl/dma_crc_pkg.sv
// Shared constants and types for the in-line DMA CRC.
// Assumes a 32-bit channel word, which is also the CRC width.
package dma_crc_pkg;
    localparam int CRC_W = 32;
    // Bit-reversed form of 0x04C11DB7, for LSB-first processing.
    localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_RESET = '1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_APPEND = 2'd2
    } crc_state_e;
endpackage

// File: rtl/crc32_word.sv
// Combinational CRC-32 step that absorbs one full word.
// Bits are consumed LSB first (reflected form), one stage per bit.
// Assumes the caller registers the result; there is no state here.
module crc32_word
    import dma_crc_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [W-1:0]     data_in,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] stage [0:W];

    assign stage[0] = crc_in;

    // One shift-and-conditional-xor stage for each data bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign stage[i+1] = (stage[i] >> 1)
                          ^ ({CRC_W{stage[i][0] ^ data_in[i]}} & POLY_REFL);
    end

    assign crc_out = stage[W];
endmodule

// File: rtl/crc_seq_ctl.sv
// Sequencer for one CRC channel. It tracks whether a transfer is
// running, raises the appended CRC write after the payload, and
// drives the interrupt hold.
// Assumes that no beats arrive while the appended write is pending.
module crc_seq_ctl
    import dma_crc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_on,
    input  logic              append_on,
    input  logic              absorb,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic              err_now,
    input  logic              xfer_done,
    input  logic              app_ack,
    output logic              in_append,
    output logic              app_req,
    output logic [ADDR_W-1:0] app_addr,
    output logic              irq_hold
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

    crc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] next_addr_q;

    logic do_append;
    assign do_append = crc_on && append_on && !err_now;

    // Next-state decision for the transfer sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_done && crc_on)
                    state_d = do_append ? ST_APPEND : ST_IDLE;
                else if (absorb)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!crc_on)
                    state_d = ST_IDLE;
                else if (xfer_done)
                    state_d = do_append ? ST_APPEND : ST_IDLE;
            end
            ST_APPEND: begin
                if (app_ack)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remembers the destination word that follows the last absorbed beat.
    always_ff @(posedge clk) begin
        if (!rst_n)      next_addr_q <= '0;
        else if (absorb) next_addr_q <= beat_addr + STEP;
    end

    assign in_append = (state_q == ST_APPEND);
    assign app_req   = in_append;
    assign app_addr  = next_addr_q;
    assign irq_hold  = (state_q != ST_IDLE);

    // R5: the request and its address wait for the acknowledge.
    assert_req_waits_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (app_req && !app_ack) |=> (app_req && $stable(app_addr)));

    // R5: an acknowledged request is withdrawn.
    assert_req_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (app_req && app_ack) |=> !app_req);

    // R6: the interrupt stays held while the write is outstanding.
    assert_hold_covers_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        app_req |-> irq_hold);
endmodule

// File: rtl/dma_crc32_inline.sv
// In-line CRC-32 for one DMA channel.
// Each qualified beat is folded into the CRC on the same edge that it
// transfers. Firmware seeds the register. The result can be appended
// as one extra write, and the channel interrupt is held until done.
// Assumes 32-bit beats. HAS_CRC=0 builds a channel without CRC
// hardware, whose enable reads back as zero.
module dma_crc32_inline
    import dma_crc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit HAS_CRC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_crc_en,
    input  logic              cfg_append_en,
    input  logic [2:0]        cfg_xfer_bytes,
    input  logic              seed_we,
    input  logic [CRC_W-1:0]  seed_data,
    input  logic              beat_valid,
    input  logic [CRC_W-1:0]  beat_data,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic              xfer_done,
    input  logic              app_ack,
    output logic [CRC_W-1:0]  crc_value,
    output logic              crc_en_rd,
    output logic              size_err,
    output logic              app_req,
    output logic [ADDR_W-1:0] app_addr,
    output logic [CRC_W-1:0]  app_data,
    output logic              irq_hold
);
    localparam int BEAT_BYTES = CRC_W / 8;

    if (HAS_CRC) begin : g_crc
        logic [CRC_W-1:0] crc_q, crc_step;
        logic             err_q;
        logic             size_ok, bad_beat, absorb, in_append;

        assign size_ok  = (cfg_xfer_bytes == 3'(BEAT_BYTES));
        assign bad_beat = cfg_crc_en && beat_valid && !size_ok;
        assign absorb   = cfg_crc_en && beat_valid && size_ok
                          && !seed_we && !in_append;

        crc32_word #(.W(CRC_W)) u_step (
            .crc_in  (crc_q),
            .data_in (beat_data),
            .crc_out (crc_step)
        );

        crc_seq_ctl #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .crc_on    (cfg_crc_en),
            .append_on (cfg_append_en),
            .absorb    (absorb),
            .beat_addr (beat_addr),
            .err_now   (err_q || bad_beat),
            .xfer_done (xfer_done),
            .app_ack   (app_ack),
            .in_append (in_append),
            .app_req   (app_req),
            .app_addr  (app_addr),
            .irq_hold  (irq_hold)
        );

        // CRC register: a seed write wins, otherwise absorb the beat.
        always_ff @(posedge clk) begin
            if (!rst_n)       crc_q <= CRC_RESET;
            else if (seed_we) crc_q <= seed_data;
            else if (absorb)  crc_q <= crc_step;
        end

        // Sticky size error, cleared by the next seed write.
        always_ff @(posedge clk) begin
            if (!rst_n)        err_q <= 1'b0;
            else if (seed_we)  err_q <= 1'b0;
            else if (bad_beat) err_q <= 1'b1;
        end

        assign crc_value = crc_q;
        assign app_data  = crc_q;
        assign size_err  = err_q;
        assign crc_en_rd = cfg_crc_en;

        // R2: a seed write lands in the register.
        assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            seed_we |=> (crc_value == $past(seed_data)));

        // R3: a beat of the wrong size leaves the CRC alone.
        assert_bad_size_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_valid && cfg_crc_en && cfg_xfer_bytes != 3'd4 && !seed_we)
            |=> $stable(crc_value));

        // R5: the appended data does not move while it is pending.
        assert_app_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (app_req && !app_ack && !seed_we) |=> $stable(app_data));

        // R7: an idle, disabled channel never starts holding.
        assert_off_no_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_crc_en && !irq_hold) |=> !irq_hold);
    end else begin : g_nocrc
        assign crc_value = '0;
        assign crc_en_rd = 1'b0;
        assign size_err  = 1'b0;
        assign app_req   = 1'b0;
        assign app_addr  = '0;
        assign app_data  = '0;
        assign irq_hold  = 1'b0;
    end
endmodule

// File: tb/sim_dma_crc32_inline.sv
`timescale 1ns/1ps
// Bench for the in-line CRC: random transfers plus directed corners.
module sim_dma_crc32_inline;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_crc_en = 1'b0, cfg_append_en = 1'b0;
    logic [2:0]  cfg_xfer_bytes = 3'd4;
    logic        seed_we = 1'b0;
    logic [31:0] seed_data = '0;
    logic        beat_valid = 1'b0;
    logic [31:0] beat_data = '0;
    logic [31:0] beat_addr = '0;
    logic        xfer_done = 1'b0, app_ack = 1'b0;
    logic [31:0] crc_value, app_addr, app_data;
    logic        crc_en_rd, size_err, app_req, irq_hold;
    logic [31:0] n_crc, n_addr, n_data;
    logic        n_en, n_err, n_req, n_hold;

    int checks = 0, errors = 0;
    logic [31:0] m_crc;

    always #2.5 clk = ~clk;

    dma_crc32_inline #(.ADDR_W(32), .HAS_CRC(1'b1)) u0 (
        .clk, .rst_n, .cfg_crc_en, .cfg_append_en, .cfg_xfer_bytes,
        .seed_we, .seed_data, .beat_valid, .beat_data, .beat_addr,
        .xfer_done, .app_ack, .crc_value, .crc_en_rd, .size_err,
        .app_req, .app_addr, .app_data, .irq_hold);

    dma_crc32_inline #(.ADDR_W(32), .HAS_CRC(1'b0)) u1 (
        .clk, .rst_n, .cfg_crc_en, .cfg_append_en, .cfg_xfer_bytes,
        .seed_we, .seed_data, .beat_valid, .beat_data, .beat_addr,
        .xfer_done, .app_ack, .crc_value(n_crc), .crc_en_rd(n_en),
        .size_err(n_err), .app_req(n_req), .app_addr(n_addr),
        .app_data(n_data), .irq_hold(n_hold));

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] d);
        for (int i = 0; i < 32; i++) begin
            logic fb;
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One edge with the given inputs; results are sampled 1 ns later.
    task automatic cyc(input logic v, input logic [31:0] d, input logic [31:0] a,
                       input logic dn, input logic sw, input logic [31:0] sd);
        @(negedge clk);
        beat_valid = v; beat_data = d; beat_addr = a; xfer_done = dn;
        seed_we = sw; seed_data = sd;
        @(posedge clk);
        #1;
        beat_valid = 1'b0; xfer_done = 1'b0; seed_we = 1'b0;
    endtask

    task automatic ack_once();
        @(negedge clk); app_ack = 1'b1;
        @(posedge clk); #1; app_ack = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R2 reset crc", crc_value, 32'hFFFFFFFF);
        chk("R2 reset flags", {29'd0, app_req, irq_hold, size_err}, 32'd0);

        // R8: enable readback with and without hardware.
        @(negedge clk); cfg_crc_en = 1'b1; cfg_append_en = 1'b0;
        #1;
        chk("R8 readback", {31'd0, crc_en_rd}, 32'd1);
        chk("R8 no hardware", {31'd0, n_en}, 32'd0);

        // R1: known vector, one zero word from an all-ones seed.
        cyc(0, 0, 0, 0, 1, 32'hFFFFFFFF);
        cyc(1, 32'h0, 32'h100, 0, 0, 0);
        chk("R1 known vector", crc_value, 32'hDEBB20E3);
        chk("R6 hold after first beat", {31'd0, irq_hold}, 32'd1);
        chk("R8 no hardware hold", {31'd0, n_hold}, 32'd0);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R6 hold released on done", {31'd0, irq_hold}, 32'd0);

        // R2: seed write and beat on the same edge; the seed wins.
        cyc(1, 32'hA5A5A5A5, 32'h0, 0, 1, 32'h12345678);
        chk("R2 seed wins", crc_value, 32'h12345678);

        // R3: wrong size leaves CRC, sets error, blocks append.
        @(negedge clk); cfg_xfer_bytes = 3'd2; cfg_append_en = 1'b1;
        cyc(1, 32'hDEADBEEF, 32'h40, 0, 0, 0);
        chk("R3 crc unchanged", crc_value, 32'h12345678);
        chk("R3 error set", {31'd0, size_err}, 32'd1);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R3 no append", {31'd0, app_req}, 32'd0);
        @(negedge clk); cfg_xfer_bytes = 3'd4;
        cyc(0, 0, 0, 0, 1, 32'hFFFFFFFF);
        chk("R3 error cleared by seed", {31'd0, size_err}, 32'd0);

        // R7: disabled channel ignores beats.
        @(negedge clk); cfg_crc_en = 1'b0;
        cyc(1, 32'h55AA55AA, 32'h80, 0, 0, 0);
        chk("R7 crc unchanged", crc_value, 32'hFFFFFFFF);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R7 no hold or request", {30'd0, irq_hold, app_req}, 32'd0);
        @(negedge clk); cfg_crc_en = 1'b1;

        // Random transfers, with done either on the last beat or after it.
        for (int t = 0; t < 40; t++) begin
            int n; logic app, late; logic [31:0] base;
            n = 1 + ($urandom % 6);
            app = $urandom % 2;
            late = $urandom % 2;
            base = ($urandom & 32'hFFF0) << 4;
            @(negedge clk); cfg_append_en = app;
            m_crc = $urandom;
            cyc(0, 0, 0, 0, 1, m_crc);
            for (int k = 0; k < n; k++) begin
                logic [31:0] d;
                d = $urandom;
                cyc(1, d, base + 32'(4 * k), (k == n - 1) && !late, 0, 0);
                m_crc = ref_step(m_crc, d);
                chk("R1 random beat", crc_value, m_crc);
                if (k == 0 && (n > 1 || late))
                    chk("R6 hold on first beat", {31'd0, irq_hold}, 32'd1);
            end
            if (late) cyc(0, 0, 0, 1, 0, 0);
            if (app) begin
                chk("R4 append request", {31'd0, app_req}, 32'd1);
                chk("R4 append data", app_data, m_crc);
                chk("R4 append addr", app_addr, base + 32'(4 * n));
                chk("R6 hold during append", {31'd0, irq_hold}, 32'd1);
                repeat ($urandom % 3) begin
                    cyc(0, 0, 0, 0, 0, 0);
                    chk("R5 request waits", {31'd0, app_req}, 32'd1);
                    chk("R5 data stable", app_data, m_crc);
                end
                ack_once();
                chk("R5 request dropped", {31'd0, app_req}, 32'd0);
                chk("R6 hold released on ack", {31'd0, irq_hold}, 32'd0);
            end else begin
                chk("R6 no hold after done", {30'd0, irq_hold, app_req}, 32'd0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule